// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between on-chip logic and an 8-bit parallel NOR flash device. A client presents one operation at a time (read a byte, program a byte, erase one 64 KB sector, or erase the whole array) on a valid/ready request port. The sequencer turns each request into the bus cycles the device expects. Erase and program requests become multi-cycle unlock command sequences, which are written to the device's command register. A read becomes a plain address-and-output-enable access. A one-cycle `done` pulse reports completion, and `rd_data` carries the byte for a read.

Program and erase completion is not timed from fixed delays. After the last command cycle the sequencer waits a programmable blind interval, because the device raises its busy indication only after a short latency. It then watches a synchronised copy of the ready/busy pin and finishes when that pin reads high. The bidirectional data bus appears as three signals: an output value, an output enable, and an input value. The pad-level tri-state buffer is built outside the block.

Top module: `nor_cmd_seq`

## Requirements
- R1: A chip erase request (`req_op` = 2'b11) issues exactly six write cycles, as (address, data): (UNLOCK_A, AAh), (UNLOCK_B, 55h), (UNLOCK_A, 80h), (UNLOCK_A, AAh), (UNLOCK_B, 55h), (UNLOCK_A, 10h). The defaults are UNLOCK_A = AAAh and UNLOCK_B = 555h.
- R2: A sector erase request (`req_op` = 2'b10) issues the same first five cycles as R1. The sixth cycle carries data 30h and an address whose bits [22:16] equal `req_addr[22:16]`, with bits [15:0] zero.
- R3: A program request (`req_op` = 2'b01) issues four write cycles: (UNLOCK_A, AAh), (UNLOCK_B, 55h), (UNLOCK_A, A0h), (`req_addr`, `req_wdata`).
- R4: A read request (`req_op` = 2'b00) issues no write cycle. It drives `req_addr` with CE# and OE# low, and returns the byte on the data bus in `rd_data` together with `done`.
- R5: During each write cycle, WE# is low for exactly WE_LOW clocks. CE# is low and the data bus is driven while WE# is low. Address and data stay unchanged during that time. WE# stays high for at least RECOV+1 clocks between two write pulses.
- R6: The data bus output enable is never asserted while OE# is low. It is already deasserted in the clock before OE# falls.
- R7: After the last command cycle of an erase or program, `done` is not raised while the device still signals busy, including the busy latency window.
- R8: `req_ready` is high only while no operation is in flight. A request is taken when `req_valid` and `req_ready` are both high. A held `req_valid` waits until the previous operation's `done` has passed. Each accepted request produces exactly one `done` pulse, in request order.
- R9: While reset is high and after it is released, CE#, OE# and WE# are high, the data bus is not driven, `done` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_op | input | 2 | 00 read, 01 program, 10 sector erase, 11 chip erase |
| req_addr | input | 23 | Target byte address (sector in bits [22:16]) |
| req_wdata | input | 8 | Byte to program |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte returned by the last read |
| flash_addr | output | 23 | Device address bus |
| flash_dq_o | output | 8 | Value driven onto the data bus |
| flash_dq_oe | output | 1 | Data bus output enable |
| flash_dq_i | input | 8 | Value seen on the data bus |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_rdy | input | 1 | Ready/busy pin, low while busy |

## Verification
Two events can meet in one cycle: an operation finishing with `done`, and a new request that the client already holds on `req_valid`. The bench provokes this by presenting a program request followed at once by a read of the same byte, keeping `req_valid` high without a gap. It compares `req_ready` on every clock with its own count of outstanding requests. It also checks that the read returns the freshly programmed value, which proves the read was not admitted before the program completed. A behavioural flash model decodes the command cycles, applies erase and program, and drops its ready pin after a latency. The bench then checks that completion never overlaps the model's busy window.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    localparam int FL_ADDR_W = 23;
    localparam int FL_DATA_W = 8;
    localparam int SECT_LSB  = 16;
    localparam int STEP_W    = 3;

    localparam logic [FL_DATA_W-1:0] KEY_1      = 8'hAA;
    localparam logic [FL_DATA_W-1:0] KEY_2      = 8'h55;
    localparam logic [FL_DATA_W-1:0] CMD_ERASE  = 8'h80;
    localparam logic [FL_DATA_W-1:0] CMD_WRITE  = 8'hA0;
    localparam logic [FL_DATA_W-1:0] CMD_WHOLE  = 8'h10;
    localparam logic [FL_DATA_W-1:0] CMD_BLOCK  = 8'h30;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_PROG  = 2'b01,
        OP_SECT  = 2'b10,
        OP_CHIP  = 2'b11
    } nor_op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CMD, S_DLY, S_POLL, S_RD_SET, S_RD_OE
    } seq_state_e;

    typedef enum logic [2:0] {
        W_IDLE, W_SETUP, W_LOW, W_HOLD, W_REC
    } wr_phase_e;

    typedef struct packed {
        logic [FL_ADDR_W-1:0] addr;
        logic [FL_DATA_W-1:0] data;
    } bus_cyc_t;

    // Index of the final command cycle for an operation.
    function automatic logic [STEP_W-1:0] seq_last(input nor_op_e op);
        return (op == OP_PROG) ? STEP_W'(3) : STEP_W'(5);
    endfunction

    // Address/data pair of one command cycle.
    function automatic bus_cyc_t seq_cycle(
        input nor_op_e              op,
        input logic [STEP_W-1:0]    step,
        input logic [FL_ADDR_W-1:0] tgt,
        input logic [FL_DATA_W-1:0] wd,
        input logic [FL_ADDR_W-1:0] ua,
        input logic [FL_ADDR_W-1:0] ub
    );
        bus_cyc_t c;
        case (step)
            3'd0:    c = '{addr: ua, data: KEY_1};
            3'd1:    c = '{addr: ub, data: KEY_2};
            3'd2:    c = '{addr: ua, data: (op == OP_PROG) ? CMD_WRITE : CMD_ERASE};
            3'd3:    c = (op == OP_PROG) ? '{addr: tgt, data: wd} : '{addr: ua, data: KEY_1};
            3'd4:    c = '{addr: ub, data: KEY_2};
            default: c = (op == OP_CHIP) ? '{addr: ua, data: CMD_WHOLE}
                       : '{addr: {tgt[FL_ADDR_W-1:SECT_LSB], {SECT_LSB{1'b0}}}, data: CMD_BLOCK};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/nor_cmd_table.sv
module nor_cmd_table
    import nor_seq_pkg::*;
#(
    parameter logic [FL_ADDR_W-1:0] UNLOCK_A = 23'h000AAA,
    parameter logic [FL_ADDR_W-1:0] UNLOCK_B = 23'h000555
) (
    input  nor_op_e              op,
    input  logic [STEP_W-1:0]    step,
    input  logic [FL_ADDR_W-1:0] tgt,
    input  logic [FL_DATA_W-1:0] wdata,
    output bus_cyc_t             cyc,
    output logic                 is_last
);
    always_comb begin
        cyc     = seq_cycle(op, step, tgt, wdata, UNLOCK_A, UNLOCK_B);
        is_last = (step == seq_last(op));
    end
endmodule

// File: rtl/nor_wr_cycle.sv
module nor_wr_cycle
    import nor_seq_pkg::*;
#(
    parameter int WE_LOW = 3,
    parameter int RECOV  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  bus_cyc_t             cyc_in,
    output logic [FL_ADDR_W-1:0] bus_addr,
    output logic [FL_DATA_W-1:0] bus_dq,
    output logic                 bus_drive,
    output logic                 bus_ce_n,
    output logic                 bus_we_n,
    output logic                 fin
);
    localparam int T_MAX = (WE_LOW > RECOV) ? WE_LOW : RECOV;
    localparam int CW    = $clog2(T_MAX + 1);

    wr_phase_e       ph;
    logic [CW-1:0]   cnt;
    bus_cyc_t        cyc_q;
    logic            fin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= W_IDLE;
            cnt   <= '0;
            cyc_q <= '0;
            fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            case (ph)
                W_IDLE: if (start) begin
                    cyc_q <= cyc_in;
                    ph    <= W_SETUP;
                end
                W_SETUP: begin
                    cnt <= CW'(WE_LOW - 1);
                    ph  <= W_LOW;
                end
                W_LOW: if (cnt == '0) ph <= W_HOLD;
                       else cnt <= cnt - 1'b1;
                W_HOLD: begin
                    cnt <= CW'(RECOV - 1);
                    ph  <= W_REC;
                end
                W_REC: if (cnt == '0) begin
                    ph    <= W_IDLE;
                    fin_q <= 1'b1;
                end else cnt <= cnt - 1'b1;
                default: ph <= W_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_addr  = cyc_q.addr;
        bus_dq    = cyc_q.data;
        bus_drive = (ph == W_SETUP) || (ph == W_LOW) || (ph == W_HOLD);
        bus_ce_n  = !bus_drive;
        bus_we_n  = (ph != W_LOW);
        fin       = fin_q;
    end
endmodule

// File: rtl/nor_sync.sv
module nor_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter logic [FL_ADDR_W-1:0] UNLOCK_A    = 23'h000AAA,
    parameter logic [FL_ADDR_W-1:0] UNLOCK_B    = 23'h000555,
    parameter int                   WE_LOW      = 3,
    parameter int                   RECOV       = 2,
    parameter int                   BUSY_DLY    = 4,
    parameter int                   READ_WAIT   = 2,
    parameter int                   SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [1:0]           req_op,
    input  logic [FL_ADDR_W-1:0] req_addr,
    input  logic [FL_DATA_W-1:0] req_wdata,
    output logic                 done,
    output logic [FL_DATA_W-1:0] rd_data,
    output logic [FL_ADDR_W-1:0] flash_addr,
    output logic [FL_DATA_W-1:0] flash_dq_o,
    output logic                 flash_dq_oe,
    input  logic [FL_DATA_W-1:0] flash_dq_i,
    output logic                 flash_ce_n,
    output logic                 flash_oe_n,
    output logic                 flash_we_n,
    input  logic                 flash_rdy
);
    localparam int CNT_MAX = (BUSY_DLY > READ_WAIT) ? BUSY_DLY : READ_WAIT;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    seq_state_e           st;
    nor_op_e              op_q;
    logic [FL_ADDR_W-1:0] tgt_q;
    logic [FL_DATA_W-1:0] wd_q;
    logic [STEP_W-1:0]    step_q;
    logic                 issue_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 done_q;
    logic [FL_DATA_W-1:0] rd_q;

    bus_cyc_t             cyc;
    logic                 last;
    logic                 wr_start, wr_fin, wr_drive, wr_ce_n, wr_we_n;
    logic [FL_ADDR_W-1:0] wr_addr;
    logic [FL_DATA_W-1:0] wr_dq;
    logic                 rdy_s;
    logic                 rd_phase;

    nor_cmd_table #(.UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)) u_tab (
        .op(op_q), .step(step_q), .tgt(tgt_q), .wdata(wd_q),
        .cyc(cyc), .is_last(last)
    );

    nor_wr_cycle #(.WE_LOW(WE_LOW), .RECOV(RECOV)) u_wr (
        .clk(clk), .rst(rst), .start(wr_start), .cyc_in(cyc),
        .bus_addr(wr_addr), .bus_dq(wr_dq), .bus_drive(wr_drive),
        .bus_ce_n(wr_ce_n), .bus_we_n(wr_we_n), .fin(wr_fin)
    );

    nor_sync #(.STAGES(SYNC_STAGES)) u_rdy (
        .clk(clk), .rst(rst), .d(flash_rdy), .q(rdy_s)
    );

    assign wr_start  = (st == S_CMD) && issue_q;
    assign req_ready = (st == S_IDLE) && !done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            op_q    <= OP_READ;
            tgt_q   <= '0;
            wd_q    <= '0;
            step_q  <= '0;
            issue_q <= 1'b0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            rd_q    <= '0;
        end else begin
            done_q <= 1'b0;
            case (st)
                S_IDLE: if (req_valid && req_ready) begin
                    op_q   <= nor_op_e'(req_op);
                    tgt_q  <= req_addr;
                    wd_q   <= req_wdata;
                    step_q <= '0;
                    if (nor_op_e'(req_op) == OP_READ) begin
                        st <= S_RD_SET;
                    end else begin
                        st      <= S_CMD;
                        issue_q <= 1'b1;
                    end
                end
                S_CMD: begin
                    if (issue_q) issue_q <= 1'b0;
                    if (wr_fin) begin
                        if (last) begin
                            st    <= S_DLY;
                            cnt_q <= CNT_W'(BUSY_DLY - 1);
                        end else begin
                            step_q  <= step_q + 1'b1;
                            issue_q <= 1'b1;
                        end
                    end
                end
                S_DLY: if (cnt_q == '0) st <= S_POLL;
                       else cnt_q <= cnt_q - 1'b1;
                S_POLL: if (rdy_s) begin
                    st     <= S_IDLE;
                    done_q <= 1'b1;
                end
                S_RD_SET: begin
                    st    <= S_RD_OE;
                    cnt_q <= CNT_W'(READ_WAIT - 1);
                end
                S_RD_OE: if (cnt_q == '0) begin
                    rd_q   <= flash_dq_i;
                    done_q <= 1'b1;
                    st     <= S_IDLE;
                end else cnt_q <= cnt_q - 1'b1;
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_phase    = (st == S_RD_SET) || (st == S_RD_OE);
        flash_addr  = rd_phase ? tgt_q : wr_addr;
        flash_dq_o  = wr_dq;
        flash_dq_oe = wr_drive && !rd_phase;
        flash_ce_n  = rd_phase ? 1'b0 : wr_ce_n;
        flash_oe_n  = (st != S_RD_OE);
        flash_we_n  = wr_we_n;
        done        = done_q;
        rd_data     = rd_q;
    end
endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk
    import nor_seq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [1:0]           req_op,
    input logic                 done,
    input logic [FL_ADDR_W-1:0] flash_addr,
    input logic [FL_DATA_W-1:0] flash_dq_o,
    input logic                 flash_dq_oe,
    input logic                 flash_ce_n,
    input logic                 flash_oe_n,
    input logic                 flash_we_n,
    input logic                 flash_rdy
);
    logic op_rd_q;

    always_ff @(posedge clk) begin
        if (rst) op_rd_q <= 1'b0;
        else if (req_valid && req_ready) op_rd_q <= (req_op == OP_READ);
    end

    p_no_contend_r6: assert property (@(posedge clk) disable iff (rst)
        !flash_oe_n |-> !flash_dq_oe);

    p_release_first_r6: assert property (@(posedge clk) disable iff (rst)
        (!flash_oe_n && $past(flash_oe_n)) |-> !$past(flash_dq_oe));

    p_we_drive_r5: assert property (@(posedge clk) disable iff (rst)
        !flash_we_n |-> (flash_dq_oe && !flash_ce_n && flash_oe_n));

    p_we_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (!flash_we_n && !$past(flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_dq_o)));

    p_rdy_done_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !op_rd_q) |-> flash_rdy);

    p_hold_off_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_done_ack_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_ready);
endmodule

bind nor_cmd_seq nor_seq_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .done(done), .flash_addr(flash_addr),
    .flash_dq_o(flash_dq_o), .flash_dq_oe(flash_dq_oe),
    .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
    .flash_we_n(flash_we_n), .flash_rdy(flash_rdy)
);

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;
    localparam int WE_LOW    = 3;
    localparam int RECOV     = 2;
    localparam int BUSY_DLY  = 4;
    localparam int READ_WAIT = 2;
    localparam int DEV_LAT   = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'b00;
    logic [22:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        done;
    logic [7:0]  rd_data;
    logic [22:0] flash_addr;
    logic [7:0]  flash_dq_o;
    logic        flash_dq_oe;
    logic [7:0]  flash_dq_i;
    logic        flash_ce_n, flash_oe_n, flash_we_n;
    logic        flash_rdy = 1'b1;

    always #4 clk = ~clk;

    nor_cmd_seq #(.WE_LOW(WE_LOW), .RECOV(RECOV), .BUSY_DLY(BUSY_DLY),
                  .READ_WAIT(READ_WAIT)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rd_data(rd_data), .flash_addr(flash_addr),
        .flash_dq_o(flash_dq_o), .flash_dq_oe(flash_dq_oe),
        .flash_dq_i(flash_dq_i), .flash_ce_n(flash_ce_n),
        .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n), .flash_rdy(flash_rdy)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural flash device ----------------
    logic [7:0]  mem [int];
    logic [30:0] dev_q [$];
    logic [30:0] seen  [$];
    int dev_lat = 0;
    int dev_len = 0;
    int dev_left = 0;

    function automatic logic [7:0] mem_rd(input int a);
        return mem.exists(a) ? mem[a] : 8'hFF;
    endfunction

    always @(flash_addr or flash_ce_n or flash_oe_n)
        flash_dq_i = (!flash_ce_n && !flash_oe_n) ? mem_rd(int'(flash_addr)) : 8'h00;

    function automatic bit dev_active();
        return (dev_lat > 0) || (dev_left > 0);
    endfunction

    task automatic dev_exec();
        int keys [$];
        if (dev_q.size() == 4 && dev_q[2][7:0] == 8'hA0) begin
            mem[int'(dev_q[3][30:8])] = mem_rd(int'(dev_q[3][30:8])) & dev_q[3][7:0];
            dev_lat = DEV_LAT; dev_len = 6;
            dev_q.delete();
        end else if (dev_q.size() == 6) begin
            if (dev_q[5][7:0] == 8'h10) mem.delete();
            else begin
                foreach (mem[k]) if (k[22:16] == dev_q[5][30:24]) keys.push_back(k);
                foreach (keys[i]) mem.delete(keys[i]);
            end
            dev_lat = DEV_LAT; dev_len = 25;
            dev_q.delete();
        end
    endtask

    // ---------------- expected command sequences ----------------
    function automatic int exp_len(input logic [1:0] op);
        return (op == 2'b00) ? 0 : (op == 2'b01) ? 4 : 6;
    endfunction

    function automatic logic [30:0] exp_cyc(input logic [1:0] op, input logic [22:0] a,
                                           input logic [7:0] d, input int i);
        if (op == 2'b01) begin
            case (i)
                0: return {23'hAAA, 8'hAA};
                1: return {23'h555, 8'h55};
                2: return {23'hAAA, 8'hA0};
                default: return {a, d};
            endcase
        end
        case (i)
            0, 3: return {23'hAAA, 8'hAA};
            1, 4: return {23'h555, 8'h55};
            2: return {23'hAAA, 8'h80};
            default: return (op == 2'b11) ? {23'hAAA, 8'h10} : {a & 23'h7F0000, 8'h30};
        endcase
    endfunction

    typedef struct packed { logic [1:0] op; logic [22:0] a; logic [7:0] d; logic [7:0] e; } req_t;
    req_t pending [$];
    logic [7:0] cur_exp = '0;

    // ---------------- per-clock reference monitor ----------------
    bit   prev_we = 1'b1;
    int   lo_cnt = 0;
    int   hi_cnt = 1000;
    logic [22:0] fall_a;
    logic [7:0]  fall_d;

    always @(posedge clk) begin
        if (rst) begin
            prev_we = 1'b1; lo_cnt = 0; hi_cnt = 1000;
        end else begin
            // write pulse timing and capture (R5)
            if (!flash_we_n) begin
                if (prev_we) begin
                    chk(hi_cnt >= RECOV + 1, "R5 we high gap", hi_cnt, RECOV + 1);
                    fall_a = flash_addr; fall_d = flash_dq_o;
                end
                lo_cnt++;
            end else begin
                if (!prev_we) begin
                    chk(lo_cnt == WE_LOW, "R5 we low width", lo_cnt, WE_LOW);
                    chk(flash_addr == fall_a && flash_dq_o == fall_d, "R5 addr/data hold",
                        {flash_addr, flash_dq_o}, {fall_a, fall_d});
                    chk(!flash_ce_n, "R5 ce low at we rise", flash_ce_n, 0);
                    seen.push_back({flash_addr, flash_dq_o});
                    dev_q.push_back({flash_addr, flash_dq_o});
                    dev_exec();
                    lo_cnt = 0; hi_cnt = 0;
                end
                hi_cnt++;
            end
            prev_we = flash_we_n;

            // device busy timing
            if (dev_lat > 0) begin
                dev_lat--;
                if (dev_lat == 0) begin flash_rdy <= 1'b0; dev_left = dev_len; end
            end else if (dev_left > 0) begin
                dev_left--;
                if (dev_left == 0) flash_rdy <= 1'b1;
            end

            if (req_valid && req_ready)
                pending.push_back('{op: req_op, a: req_addr, d: req_wdata, e: cur_exp});

            if (done) begin
                if (pending.size() == 0) chk(0, "R8 done without request", 1, 0);
                else begin
                    req_t r;
                    r = pending.pop_front();
                    chk(seen.size() == exp_len(r.op), "R1/R2/R3/R4 cycle count", seen.size(), exp_len(r.op));
                    for (int i = 0; i < seen.size() && i < exp_len(r.op); i++) begin
                        if (r.op == 2'b11)      chk(seen[i] == exp_cyc(r.op, r.a, r.d, i), "R1 chip erase cycle", seen[i], exp_cyc(r.op, r.a, r.d, i));
                        else if (r.op == 2'b10) chk(seen[i] == exp_cyc(r.op, r.a, r.d, i), "R2 sector erase cycle", seen[i], exp_cyc(r.op, r.a, r.d, i));
                        else                    chk(seen[i] == exp_cyc(r.op, r.a, r.d, i), "R3 program cycle", seen[i], exp_cyc(r.op, r.a, r.d, i));
                    end
                    if (r.op == 2'b00) chk(rd_data == r.e, "R4 read data", rd_data, r.e);
                    else chk(!dev_active() && flash_rdy, "R7 done while busy", dev_active(), 0);
                end
                seen.delete();
            end
        end
    end

    // compare handshake and bus discipline away from the edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(req_ready == (pending.size() == 0), "R8 ready vs outstanding", req_ready, pending.size() == 0);
            chk(!( !flash_oe_n && flash_dq_oe), "R6 bus contention", flash_dq_oe, 0);
            if (!flash_oe_n) chk(flash_we_n, "R4 we high during read", flash_we_n, 1);
        end
    end

    // ---------------- watchdog ----------------
    int cyc_cnt = 0;
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc_cnt);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input logic [1:0] op, input logic [22:0] a, input logic [7:0] d, input logic [7:0] e);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d; cur_exp = e;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        req_valid = 1'b0;
        while (pending.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_op(input logic [1:0] op, input logic [22:0] a, input logic [7:0] d, input logic [7:0] e);
        send(op, a, d, e);
        wait_idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state, during reset
        chk(flash_ce_n && flash_oe_n && flash_we_n && !flash_dq_oe, "R9 strobes in reset",
            {flash_ce_n, flash_oe_n, flash_we_n, flash_dq_oe}, 4'b1110);
        chk(!done && req_ready, "R9 handshake in reset", {done, req_ready}, 2'b01);
        rst = 1'b0;
        @(negedge clk);
        chk(flash_ce_n && flash_oe_n && flash_we_n && !flash_dq_oe && !done && req_ready,
            "R9 idle after reset", {flash_ce_n, flash_oe_n, flash_we_n, flash_dq_oe, done, req_ready}, 6'b111001);

        do_op(2'b00, 23'h000100, 8'h00, 8'hFF);          // R4 erased read
        do_op(2'b01, 23'h012345, 8'h5A, 8'h00);          // R3 program
        do_op(2'b00, 23'h012345, 8'h00, 8'h5A);          // R4 read back
        do_op(2'b01, 23'h012345, 8'h0F, 8'h00);          // R3 clears bits only
        do_op(2'b00, 23'h012345, 8'h00, 8'h0A);
        do_op(2'b01, 23'h02ABCD, 8'h33, 8'h00);
        do_op(2'b01, 23'h03ABCD, 8'h44, 8'h00);
        do_op(2'b10, 23'h02FFFF, 8'h00, 8'h00);          // R2 sector erase
        do_op(2'b00, 23'h02ABCD, 8'h00, 8'hFF);
        do_op(2'b00, 23'h03ABCD, 8'h00, 8'h44);          // R2 other sector kept

        // R8: program then read held back-to-back with req_valid high
        send(2'b01, 23'h040000, 8'h77, 8'h00);
        send(2'b00, 23'h040000, 8'h00, 8'h77);
        wait_idle();

        do_op(2'b11, 23'h000000, 8'h00, 8'h00);          // R1 chip erase
        do_op(2'b00, 23'h03ABCD, 8'h00, 8'hFF);
        do_op(2'b00, 23'h012345, 8'h00, 8'hFF);
        do_op(2'b00, 23'h040000, 8'h00, 8'hFF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule